// File: doc/BRIEF.md
# Per-Frame CRC Load Checker

This block sits in the configuration load path and checks incoming configuration data one frame at a time. A frame is a fixed number of 32-bit payload words followed by a single check word. The check word carries the expected 16-bit CRC in its low half. The block folds one whole payload word into a running CRC on every accepted beat. When the check word arrives, it compares the computed value with the expected one.

When the two values agree, the computed CRC is written into a per-frame check-bit store at the index of that frame, and loading moves on to the next frame. When they disagree, loading stops: a sticky error flag rises, the index of the failing frame is held, and the input is no longer accepted until reset. After the final frame checks clean, a one-cycle completion pulse is given. The store then holds one 16-bit entry per frame, and it can be read back through a registered read port by a later background scrubber. The good-frame count stays on an output.

Top module: `cfg_frame_crc_loader`

## Requirements
- R1: While reset is asserted, and after it is released, in_ready is 1, crc_err is 0, done is 0 and frames_ok is 0.
- R2: The CRC of a frame uses the generator 0x1021 (x^16+x^12+x^5+1), non-reflected. It starts from 0xFFFF and shifts in each payload word most significant bit first, in arrival order, with one whole word taken per accepted beat.
- R3: When a frame checks clean, the computed CRC is written to store entry k, where k is the number of frames already accepted since reset (the first frame is 0). Driving rd_addr with k gives that entry on rd_data one clock later.
- R4: frames_ok rises by exactly one in the cycle after each clean check word is accepted, and otherwise holds.
- R5: If the low 16 bits of a check word differ from the computed CRC, then from the next cycle crc_err is 1 and err_frame holds the failing frame's index. in_ready stays 0 until reset, and frames_ok and the store entry of that frame keep their previous values.
- R6: done is high for exactly one cycle, the cycle after the check word of frame NUM_FRAMES-1 is accepted cleanly; frames_ok then equals NUM_FRAMES. After that, in_ready is 0 and further beats change nothing.
- R7: A beat transfers only when in_valid and in_ready are both 1. Data presented while in_valid is 0 has no effect on the CRC.
- R8: Bits 31:16 of a check word are ignored.
- R9: The CRC restarts at 0xFFFF for every frame, so two frames with identical payloads produce identical store entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word is present |
| in_data | input | 32 | Payload word, or check word with the CRC in bits 15:0 |
| in_ready | output | 1 | Block accepts a word this cycle |
| rd_addr | input | IDX_W (3) | Store entry to read |
| rd_data | output | 16 | Store entry read one cycle after rd_addr |
| crc_err | output | 1 | Sticky mismatch flag |
| err_frame | output | IDX_W (3) | Index of the frame that failed |
| done | output | 1 | One-cycle pulse after the last frame checks clean |
| frames_ok | output | CNT_W (4) | Number of frames accepted cleanly |

## Verification
A corrupted running CRC or a word counter that is off by one shows up at the ports on the very next check word: crc_err rises one cycle after that word when it should not, or a stored entry read back differs from the value the bench computed. A frame index that goes wrong shows within one frame, either as a frames_ok step of the wrong size or as a good CRC landing in the wrong store entry. A state machine that fails to halt after an error or after completion is caught by driving extra beats and watching frames_ok, done and in_ready stay put.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int DATA_W = 32;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_PAYLOAD  = 2'd0,
    ST_CHECK    = 2'd1,
    ST_FAULT    = 2'd2,
    ST_FINISHED = 2'd3
  } ld_state_e;

  // Whole-word CRC update: the bit loop unrolls into one XOR network.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/crc16_word_accum.sv
module crc16_word_accum
  import frame_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             crc_en;

  always_comb begin
    crc_en = clear | step;
    if (clear) crc_d = CRC_INIT;
    else       crc_d = crc_fold(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/frame_load_ctrl.sv
module frame_load_ctrl
  import frame_crc_pkg::*;
#(
  parameter int WORDS_PER_FRAME = 4,
  parameter int NUM_FRAMES      = 8,
  parameter int IDX_W           = 3,
  parameter int CNT_W           = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CRC_W-1:0] chk_lo,
  input  logic [CRC_W-1:0] crc_cur,
  output logic             in_ready,
  output logic             crc_clear,
  output logic             crc_step,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             crc_err,
  output logic [IDX_W-1:0] err_frame,
  output logic             done,
  output logic [CNT_W-1:0] frames_ok
);
  localparam int WCNT_W = $clog2(WORDS_PER_FRAME + 1);
  localparam logic [WCNT_W-1:0] LAST_WORD  = WCNT_W'(WORDS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0]  LAST_FRAME = CNT_W'(NUM_FRAMES - 1);

  ld_state_e        state_q, state_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic [IDX_W-1:0]  errf_q;
  logic              done_q, done_d;
  logic              accept, match, fault_set;

  assign in_ready = (state_q == ST_PAYLOAD) || (state_q == ST_CHECK);
  assign accept   = in_valid && in_ready;
  assign match    = (chk_lo == crc_cur);

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    done_d    = 1'b0;
    crc_step  = 1'b0;
    crc_clear = 1'b0;
    wr_en     = 1'b0;
    fault_set = 1'b0;
    case (state_q)
      ST_PAYLOAD: begin
        if (accept) begin
          crc_step = 1'b1;
          if (wcnt_q == LAST_WORD) begin
            wcnt_d  = '0;
            state_d = ST_CHECK;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (accept) begin
          crc_clear = 1'b1;
          if (match) begin
            wr_en = 1'b1;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_FRAME) begin
              state_d = ST_FINISHED;
              done_d  = 1'b1;
            end else begin
              state_d = ST_PAYLOAD;
            end
          end else begin
            err_d     = 1'b1;
            fault_set = 1'b1;
            state_d   = ST_FAULT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAYLOAD;
      wcnt_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      errf_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
      if (fault_set) errf_q <= cnt_q[IDX_W-1:0];
    end
  end

  assign wr_idx    = cnt_q[IDX_W-1:0];
  assign crc_err   = err_q;
  assign err_frame = errf_q;
  assign done      = done_q;
  assign frames_ok = cnt_q;

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> crc_err);
  p_no_ready_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> !in_ready);
  p_errframe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> $stable(err_frame));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frames_ok == CNT_W'(NUM_FRAMES)));
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((frames_ok == $past(frames_ok)) || (frames_ok == $past(frames_ok) + 1'b1)));
endmodule

// File: rtl/crc_check_store.sv
module crc_check_store
  import frame_crc_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CRC_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [CRC_W-1:0] rdata
);
  logic [CRC_W-1:0] entry_q [NUM_FRAMES];
  logic [CRC_W-1:0] rdata_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
    logic sel;
    assign sel = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel) entry_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata_q <= entry_q[raddr];
  end

  assign rdata = rdata_q;

  p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < NUM_FRAMES));
endmodule

// File: rtl/cfg_frame_crc_loader.sv
module cfg_frame_crc_loader
  import frame_crc_pkg::*;
#(
  parameter  int WORDS_PER_FRAME = 4,
  parameter  int NUM_FRAMES      = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [CRC_W-1:0]  rd_data,
  output logic              crc_err,
  output logic [IDX_W-1:0]  err_frame,
  output logic              done,
  output logic [CNT_W-1:0]  frames_ok
);
  logic             rs_q1, rs_q2, rst_int_n;
  logic             crc_clear, crc_step, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [CRC_W-1:0] crc_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  crc16_word_accum u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (crc_clear),
    .step  (crc_step),
    .data  (in_data),
    .crc   (crc_value)
  );

  frame_load_ctrl #(
    .WORDS_PER_FRAME (WORDS_PER_FRAME),
    .NUM_FRAMES      (NUM_FRAMES),
    .IDX_W           (IDX_W),
    .CNT_W           (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .chk_lo    (in_data[CRC_W-1:0]),
    .crc_cur   (crc_value),
    .in_ready  (in_ready),
    .crc_clear (crc_clear),
    .crc_step  (crc_step),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .crc_err   (crc_err),
    .err_frame (err_frame),
    .done      (done),
    .frames_ok (frames_ok)
  );

  crc_check_store #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (crc_value),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  p_crc_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(in_valid && in_ready) |=> $stable(crc_value));
  p_crc_restart_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    crc_clear |=> (crc_value == CRC_INIT));
endmodule

// File: tb/tb_cfg_frame_crc_loader.sv
module tb_cfg_frame_crc_loader;
  localparam int WPF = 4;
  localparam int NF  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        crc_err;
  logic [2:0]  err_frame;
  logic        done;
  logic [3:0]  frames_ok;

  int checks = 0;
  int fails  = 0;
  logic [31:0] pay [WPF];
  logic [15:0] run1 [NF];
  logic [15:0] run2 [NF];

  always #10 clk = ~clk;

  cfg_frame_crc_loader #(.WORDS_PER_FRAME(WPF), .NUM_FRAMES(NF)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .crc_err(crc_err), .err_frame(err_frame), .done(done), .frames_ok(frames_ok)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'hFFFF;
    logic        fb;
    for (int w = 0; w < WPF; w++)
      for (int b = 31; b >= 0; b--) begin
        fb = c[15] ^ pay[w][b];
        c  = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic drive_beat(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;   // junk while not valid (R7)
    end
  endtask

  // Ends at the negedge after the check word's capture edge.
  task automatic send_frame(input logic [15:0] hi, input bit bad, output logic [15:0] c);
    c = ref_crc();
    for (int w = 0; w < WPF; w++) begin
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
      drive_beat(pay[w]);
    end
    if ($urandom % 2 == 0) idle(1 + $urandom % 2);
    drive_beat({hi, bad ? (c ^ 16'h8001) : c});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_store(input int idx, output logic [15:0] v);
    @(negedge clk);
    rd_addr = idx[2:0];
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    rd_addr  = '0;
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    check("R1", "crc_err in reset", 32'(crc_err), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "in_ready after reset", 32'(in_ready), 32'd1);
    check("R1", "crc_err after reset", 32'(crc_err), 32'd0);
    check("R1", "done after reset", 32'(done), 32'd0);
    check("R1", "frames_ok after reset", 32'(frames_ok), 32'd0);
  endtask

  task automatic fill_random();
    for (int w = 0; w < WPF; w++) pay[w] = $urandom;
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    report();
  end

  initial begin
    logic [15:0] c, v;
    void'($urandom(32'd2024));

    // Full clean load
    do_reset();
    for (int f = 0; f < NF; f++) begin
      if (f == 0)      for (int w = 0; w < WPF; w++) pay[w] = 32'h0000_0000;
      else if (f == 1) for (int w = 0; w < WPF; w++) pay[w] = 32'hFFFF_FFFF;
      else if (f != 4) fill_random();   // frame 4 repeats frame 3 (R9)
      send_frame((f == 2) ? 16'hDEAD : 16'($urandom), 1'b0, c);   // R8 junk upper bits
      run1[f] = c;
      check("R4", "frames_ok step", 32'(frames_ok), 32'(f + 1));
      check("R5", "no error on clean frame", 32'(crc_err), 32'd0);
      check("R6", "done timing", 32'(done), (f == NF - 1) ? 32'd1 : 32'd0);
    end
    @(negedge clk);
    check("R6", "done one cycle", 32'(done), 32'd0);
    check("R6", "in_ready after finish", 32'(in_ready), 32'd0);
    drive_beat(32'h1234_5678);
    drive_beat(32'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "frames_ok held after finish", 32'(frames_ok), 32'(NF));
    check("R6", "no second done", 32'(done), 32'd0);
    for (int f = 0; f < NF; f++) begin
      read_store(f, v);
      check((f == 4) ? "R9" : "R3", "store entry (R2 crc)", 32'(v), 32'(run1[f]));
    end

    // Mismatch on frame 2
    do_reset();
    for (int f = 0; f < 2; f++) begin
      fill_random();
      send_frame(16'h0, 1'b0, c);
      run2[f] = c;
    end
    fill_random();
    pay[0] = pay[0] ^ 32'h1;
    send_frame(16'h0, 1'b1, c);
    check("R5", "crc_err raised", 32'(crc_err), 32'd1);
    check("R5", "err_frame", 32'(err_frame), 32'd2);
    check("R5", "in_ready low", 32'(in_ready), 32'd0);
    check("R5", "frames_ok held", 32'(frames_ok), 32'd2);
    check("R5", "no done", 32'(done), 32'd0);
    for (int i = 0; i < 3; i++) drive_beat($urandom);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", "crc_err sticky", 32'(crc_err), 32'd1);
    check("R5", "frames_ok after ignored beats", 32'(frames_ok), 32'd2);
    check("R5", "in_ready stays low", 32'(in_ready), 32'd0);
    read_store(2, v);
    check("R5", "failed frame entry untouched", 32'(v), 32'(run1[2]));
    for (int f = 0; f < 2; f++) begin
      read_store(f, v);
      check("R3", "store entry second run", 32'(v), 32'(run2[f]));
    end

    // Mismatch on the first frame; high half correct-looking junk
    do_reset();
    fill_random();
    send_frame(16'hFFFF, 1'b1, c);
    check("R5", "err on frame 0", 32'(crc_err), 32'd1);
    check("R5", "err_frame 0", 32'(err_frame), 32'd0);
    check("R4", "frames_ok zero", 32'(frames_ok), 32'd0);

    // Back to back with no stalls, single clean frame after reset
    do_reset();
    fill_random();
    c = ref_crc();
    for (int w = 0; w < WPF; w++) drive_beat(pay[w]);
    drive_beat({16'h5A5A, c});
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", "back-to-back frame accepted", 32'(frames_ok), 32'd1);
    check("R8", "upper bits ignored", 32'(crc_err), 32'd0);
    read_store(0, v);
    check("R2", "crc of back-to-back frame", 32'(v), 32'(c));

    report();
  end
endmodule